// File: doc/BRIEF.md
# Memory Protection Entry Write Guard

This block stores the configuration bytes and address registers of a parameterised number of memory protection entries, together with three machine security control bits: lockdown, whitelist-default and lock-bypass. A single write port carries every register update. For each write the block decides whether the value is stored or dropped, and one cycle later it reports the outcome as a two-bit reason code. Lock rules, the lock bypass, lockdown encoding rules and the check against the following entry's top-of-range mode all enter into that decision.

A combinational read port returns any stored register. Indices past the implemented count read as zero. After every accepted address write, a per-entry pulse tells downstream match logic which entry rules have to be recomputed. Permission checking against addresses lies outside this block.

Top module: `pmp_cfg_guard`

## Requirements
- R1: A configuration byte carries read at bit 0, write at bit 1, execute at bit 2, match mode at bits 4:3 (01 is top-of-range, 00 is off) and lock at bit 7. Writes to the config space use wr_data[7:0], and reads return that byte zero-extended. The select codes are 0 for config, 1 for address, 2 for security and 3 for reserved.
- R2: An entry is read-only when its lock bit is 1 and the lock-bypass bit is 0. A changing write to the config byte or the address of a read-only entry is dropped with code 1. When lock-bypass is 1, such writes are stored.
- R3: When lockdown is 1 and lock-bypass is 0, a config write whose operation index {lock, read, write, execute} (lock as the MSB) is 9, 10, 11 or 13 is dropped with code 2. Every other index is stored.
- R4: A config or address write that equals the stored value changes nothing, reports code 0 and produces no rule-change pulse. This holds even for a locked entry.
- R5: An address write to entry i is dropped with code 1 when entry i+1 exists, is read-only and has match mode top-of-range. The last entry has no successor to check.
- R6: In a security write, bit 2 requests lock-bypass. A request for 1 while lock-bypass is 0 and any implemented entry has its lock bit set is dropped with code 1. Otherwise lock-bypass takes bit 2.
- R7: Lockdown (security bit 0) and whitelist-default (bit 1) are set by writing 1. After that they stay 1 until reset.
- R8: A config or address write at an index at or above NUM_ENTRIES, or a write with select 3, is dropped with code 3. Reads of such indices, or with select 3, return zero. A security read returns {lock-bypass, whitelist-default, lockdown} in bits 2:0.
- R9: An accepted address write to entry i pulses rule_chg[i] for one cycle. It also pulses rule_chg[i+1] when entry i+1 is in top-of-range mode.
- R10: Every write produces ack_valid for exactly the next cycle, with its reason code: 0 accepted, 1 read-only, 2 invalid encoding, 3 out of range. With no write, ack_valid is 0.
- R11: Reset clears all config bytes, address registers and security bits, and clears ack_valid and rule_chg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| wr_sel | input | 2 | Target space: 0 config, 1 address, 2 security, 3 reserved |
| wr_idx | input | IDX_W | Entry index |
| wr_data | input | ADDR_W | Write value |
| rd_sel | input | 2 | Read space, same coding as wr_sel |
| rd_idx | input | IDX_W | Read entry index |
| rd_data | output | ADDR_W | Combinational read value |
| ack_valid | output | 1 | Write outcome valid, one cycle after the write |
| ack_code | output | 2 | Reason code of that write |
| rule_chg | output | NUM_ENTRIES | Per-entry rule recompute pulse |
| sec_mml | output | 1 | Lockdown bit |
| sec_mmwp | output | 1 | Whitelist-default bit |
| sec_rlb | output | 1 | Lock-bypass bit |

## Verification
Config writes are tried on unlocked entries, on locked entries with bypass off and with bypass on, and with every forbidden lockdown encoding next to neighbouring legal ones such as 5, 12 and 15. This tells the lock path apart from the encoding path. Address writes are sent with a successor that is unlocked top-of-range, locked top-of-range and locked in another mode, which separates the successor guard from the entry's own lock and exposes which rule-change bits fire. Writes that repeat a stored value, out-of-range indices, the reserved select, and a bypass request made with and without locked entries each pin down one ordering of the reason checks.

// File: rtl/pmp_guard_pkg.sv
// Shared constants and helpers for the protection-entry write guard.
// Assumes an 8-bit configuration byte layout fixed by the match logic.
package pmp_guard_pkg;
    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_SEC  = 2'd2;

    localparam int CFG_R = 0;
    localparam int CFG_W = 1;
    localparam int CFG_X = 2;
    localparam int CFG_L = 7;
    localparam logic [1:0] MODE_TOR = 2'b01;

    localparam int SEC_LOCKDOWN = 0;
    localparam int SEC_WLDEF    = 1;
    localparam int SEC_BYPASS   = 2;

    typedef enum logic [1:0] {
        RC_OK  = 2'd0,
        RC_RO  = 2'd1,
        RC_BAD = 2'd2,
        RC_OOR = 2'd3
    } rcode_e;

    // Operation index {lock, read, write, execute}.
    function automatic logic [3:0] op_index(input logic [7:0] cfg);
        return {cfg[CFG_L], cfg[CFG_R], cfg[CFG_W], cfg[CFG_X]};
    endfunction

    // Encodings that would give execute to machine-only or locked shared regions.
    function automatic logic op_forbidden(input logic [3:0] op);
        return (op == 4'd9) || (op == 4'd10) || (op == 4'd11) || (op == 4'd13);
    endfunction
endpackage

// File: rtl/pmp_entry_bank.sv
// Register bank holding the configuration byte and address of every entry.
// Assumes the write-enable vectors are already one-hot or zero.
module pmp_entry_bank #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_ENTRIES-1:0]                 cfg_we,
    input  logic [NUM_ENTRIES-1:0]                 addr_we,
    input  logic [ADDR_W-1:0]                      wdata,
    output logic [NUM_ENTRIES-1:0][7:0]            cfg_q,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]     addr_q
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        // Store the configuration byte of entry g.
        always_ff @(posedge clk) begin
            if (!rst_n)         cfg_q[g] <= '0;
            else if (cfg_we[g]) cfg_q[g] <= wdata[7:0];
        end
        // Store the address register of entry g.
        always_ff @(posedge clk) begin
            if (!rst_n)          addr_q[g] <= '0;
            else if (addr_we[g]) addr_q[g] <= wdata;
        end
    end
endmodule

// File: rtl/pmp_sec_bits.sv
// Security control bits: lockdown and whitelist-default are sticky, and the
// bypass bit follows the write unless the judge blocked the set request.
module pmp_sec_bits (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_we,
    input  logic [2:0] sec_wd,
    input  logic       bypass_blk,
    output logic       lockdown,
    output logic       wldef,
    output logic       bypass
);
    import pmp_guard_pkg::*;

    // Update the three security bits on an accepted security write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lockdown <= 1'b0;
            wldef    <= 1'b0;
            bypass   <= 1'b0;
        end else if (sec_we) begin
            lockdown <= lockdown | sec_wd[SEC_LOCKDOWN];
            wldef    <= wldef | sec_wd[SEC_WLDEF];
            bypass   <= bypass_blk ? bypass : sec_wd[SEC_BYPASS];
        end
    end
endmodule

// File: rtl/pmp_write_judge.sv
// Combinational legality decision for one write. It produces the
// write enables, the reason code and the rule-change vector.
// Assumes NUM_ENTRIES <= 2**IDX_W.
module pmp_write_judge #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 4,
    parameter int ADDR_W      = 32
) (
    input  logic                               wr_en,
    input  logic [1:0]                         wr_sel,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [ADDR_W-1:0]                  wr_data,
    input  logic [NUM_ENTRIES-1:0][7:0]        cfg_q,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addr_q,
    input  logic                               lockdown,
    input  logic                               bypass,
    output logic [NUM_ENTRIES-1:0]             cfg_we,
    output logic [NUM_ENTRIES-1:0]             addr_we,
    output logic                               sec_we,
    output logic                               bypass_blk,
    output pmp_guard_pkg::rcode_e              code,
    output logic [NUM_ENTRIES-1:0]             chg
);
    import pmp_guard_pkg::*;

    logic [NUM_ENTRIES-1:0] hit, ro, tor, lockv, succ_tor;
    logic                   in_range, cur_ro, succ_guard, any_lock;
    logic [7:0]             cur_cfg;
    logic [ADDR_W-1:0]      cur_addr;

    // Per-entry lock state and selection of the addressed entry.
    always_comb begin
        cur_cfg    = '0;
        cur_addr   = '0;
        succ_guard = 1'b0;
        succ_tor   = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            hit[i]   = (wr_idx == IDX_W'(i));
            lockv[i] = cfg_q[i][CFG_L];
            ro[i]    = cfg_q[i][CFG_L] & ~bypass;
            tor[i]   = (cfg_q[i][4:3] == MODE_TOR);
            if (hit[i]) begin
                cur_cfg  = cfg_q[i];
                cur_addr = addr_q[i];
            end
        end
        for (int i = 0; i < NUM_ENTRIES - 1; i++) begin
            if (hit[i]) begin
                succ_guard    = ro[i+1] & tor[i+1];
                succ_tor[i+1] = tor[i+1];
            end
        end
        in_range = |hit;
        cur_ro   = |(hit & ro);
        any_lock = |lockv;
    end

    // Ordered legality checks for the selected target space.
    always_comb begin
        cfg_we     = '0;
        addr_we    = '0;
        sec_we     = 1'b0;
        bypass_blk = 1'b0;
        chg        = '0;
        code       = RC_OK;
        if (wr_en) begin
            case (wr_sel)
                SEL_CFG: begin
                    if (!in_range)                      code = RC_OOR;
                    else if (wr_data[7:0] == cur_cfg)   code = RC_OK;
                    else if (cur_ro)                    code = RC_RO;
                    else if (lockdown && !bypass &&
                             op_forbidden(op_index(wr_data[7:0])))
                                                        code = RC_BAD;
                    else                                cfg_we = hit;
                end
                SEL_ADDR: begin
                    if (!in_range)                      code = RC_OOR;
                    else if (wr_data == cur_addr)       code = RC_OK;
                    else if (succ_guard || cur_ro)      code = RC_RO;
                    else begin
                        addr_we = hit;
                        chg     = hit | succ_tor;
                    end
                end
                SEL_SEC: begin
                    sec_we = 1'b1;
                    if (wr_data[SEC_BYPASS] && !bypass && any_lock) begin
                        bypass_blk = 1'b1;
                        code       = RC_RO;
                    end
                end
                default: code = RC_OOR;
            endcase
        end
    end
endmodule

// File: rtl/pmp_cfg_guard.sv
// Top of the write guard. It ties the judge to the entry bank and the
// security bits, registers the write outcome and serves combinational reads.
// Assumes one write per cycle and NUM_ENTRIES <= 2**IDX_W, ADDR_W >= 8.
module pmp_cfg_guard #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 4,
    parameter int ADDR_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [ADDR_W-1:0]      wr_data,
    input  logic [1:0]             rd_sel,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [ADDR_W-1:0]      rd_data,
    output logic                   ack_valid,
    output logic [1:0]             ack_code,
    output logic [NUM_ENTRIES-1:0] rule_chg,
    output logic                   sec_mml,
    output logic                   sec_mmwp,
    output logic                   sec_rlb
);
    import pmp_guard_pkg::*;

    logic [NUM_ENTRIES-1:0][7:0]        cfg_q;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addr_q;
    logic [NUM_ENTRIES-1:0]             cfg_we, addr_we, chg_d;
    logic                               sec_we, bypass_blk;
    rcode_e                             code_d;

    pmp_write_judge #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_judge (
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .cfg_q(cfg_q), .addr_q(addr_q), .lockdown(sec_mml), .bypass(sec_rlb),
        .cfg_we(cfg_we), .addr_we(addr_we), .sec_we(sec_we),
        .bypass_blk(bypass_blk), .code(code_d), .chg(chg_d)
    );

    pmp_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .addr_we(addr_we),
        .wdata(wr_data), .cfg_q(cfg_q), .addr_q(addr_q)
    );

    pmp_sec_bits u_sec (
        .clk(clk), .rst_n(rst_n), .sec_we(sec_we), .sec_wd(wr_data[2:0]),
        .bypass_blk(bypass_blk), .lockdown(sec_mml), .wldef(sec_mmwp),
        .bypass(sec_rlb)
    );

    // Register the outcome of this cycle's write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_code  <= 2'd0;
            rule_chg  <= '0;
        end else begin
            ack_valid <= wr_en;
            ack_code  <= code_d;
            rule_chg  <= chg_d;
        end
    end

    // Combinational read mux; unknown indices and the reserved select give zero.
    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_SEC) begin
            rd_data[SEC_LOCKDOWN] = sec_mml;
            rd_data[SEC_WLDEF]    = sec_mmwp;
            rd_data[SEC_BYPASS]   = sec_rlb;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (rd_idx == IDX_W'(i)) begin
                    if (rd_sel == SEL_CFG)       rd_data = {{(ADDR_W-8){1'b0}}, cfg_q[i]};
                    else if (rd_sel == SEL_ADDR) rd_data = addr_q[i];
                end
            end
        end
    end
endmodule

// File: rtl/pmp_cfg_guard_chk.sv
// Assertion checker for the write guard, attached to every instance by bind.
module pmp_cfg_guard_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [1:0]                    wr_sel,
    input logic [IDX_W-1:0]              wr_idx,
    input logic [7:0]                    wr_low,
    input logic [NUM_ENTRIES-1:0][7:0]   cfg_q,
    input logic                          ack_valid,
    input logic [1:0]                    ack_code,
    input logic [NUM_ENTRIES-1:0]        rule_chg,
    input logic                          sec_mml,
    input logic                          sec_mmwp,
    input logic                          sec_rlb
);
    logic any_lock, tgt_lock, tgt_in;

    // Observed lock state of the entry under write and of the whole bank.
    always_comb begin
        any_lock = 1'b0;
        tgt_lock = 1'b0;
        tgt_in   = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            any_lock = any_lock | cfg_q[i][7];
            if (wr_idx == IDX_W'(i)) begin
                tgt_in   = 1'b1;
                tgt_lock = cfg_q[i][7];
            end
        end
    end

    a_r10_ack_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ack_valid);
    a_r10_no_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !ack_valid);
    a_r2_locked_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && tgt_in && tgt_lock && !sec_rlb) |=> $stable(cfg_q));
    a_r6_bypass_set_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && wr_low[2] && !sec_rlb && any_lock) |=> !sec_rlb);
    a_r7_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sec_mml |=> sec_mml);
    a_r7_wldef_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sec_mmwp |=> sec_mmwp);
    a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd2 && !tgt_in) |=> (ack_code == 2'd3 && rule_chg == '0));
    a_r9_chg_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|rule_chg) |-> (ack_valid && ack_code == 2'd0));
endmodule

bind pmp_cfg_guard pmp_cfg_guard_chk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_low(wr_data[7:0]), .cfg_q(cfg_q), .ack_valid(ack_valid),
    .ack_code(ack_code), .rule_chg(rule_chg), .sec_mml(sec_mml),
    .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb)
);

// File: tb/pmp_cfg_guard_bench.sv
module pmp_cfg_guard_bench;
    localparam int NE = 8;
    localparam int IW = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [IW-1:0] wr_idx = '0;
    logic [AW-1:0] wr_data = '0;
    logic [1:0]    rd_sel = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [AW-1:0] rd_data;
    logic          ack_valid;
    logic [1:0]    ack_code;
    logic [NE-1:0] rule_chg;
    logic          sec_mml, sec_mmwp, sec_rlb;

    pmp_cfg_guard #(.NUM_ENTRIES(NE), .IDX_W(IW), .ADDR_W(AW)) u_pmp_cfg_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .ack_valid(ack_valid), .ack_code(ack_code), .rule_chg(rule_chg),
        .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    // Reference state.
    logic [7:0]    m_cfg [NE];
    logic [AW-1:0] m_addr[NE];
    logic          m_ld, m_wl, m_bp;
    logic          exp_ack = 1'b0;
    logic [1:0]    exp_code = '0;
    logic [NE-1:0] exp_chg = '0;
    logic [5:0]    rd_cnt = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < NE; i++) begin
            m_cfg[i]  = '0;
            m_addr[i] = '0;
        end
        m_ld = 0; m_wl = 0; m_bp = 0;
    endfunction

    function automatic logic [AW-1:0] model_read(input logic [1:0] s, input int idx);
        if (s == 2) return {29'd0, m_bp, m_wl, m_ld};
        if (idx >= NE || s == 3) return '0;
        if (s == 0) return {24'd0, m_cfg[idx]};
        return m_addr[idx];
    endfunction

    function automatic bit entry_locked(input int idx);
        return m_cfg[idx][7] && !m_bp;
    endfunction

    // Rotate the read port through every select and index, away from the edges.
    always @(posedge clk) begin
        #2;
        rd_cnt = rd_cnt + 1'b1;
        rd_sel = rd_cnt[5:4];
        rd_idx = rd_cnt[3:0];
    end

    // Compare every observable output against the reference at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(ack_valid == exp_ack, (exp_ack ? "R10" : cur_req), "ack_valid", AW'(ack_valid), AW'(exp_ack));
            if (exp_ack) check(ack_code == exp_code, cur_req, "ack_code", AW'(ack_code), AW'(exp_code));
            check(rule_chg == exp_chg, "R9", "rule_chg", AW'(rule_chg), AW'(exp_chg));
            check({sec_rlb, sec_mmwp, sec_mml} == {m_bp, m_wl, m_ld}, cur_req, "sec bits",
                  AW'({sec_rlb, sec_mmwp, sec_mml}), AW'({m_bp, m_wl, m_ld}));
            check(rd_data == model_read(rd_sel, int'(rd_idx)), cur_req, "rd_data",
                  rd_data, model_read(rd_sel, int'(rd_idx)));
            exp_ack = 1'b0;
            exp_chg = '0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        model_clear();
        exp_ack = 1'b0;
        exp_chg = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write: apply it, predict it, then compare the code with the intent.
    task automatic wr(input logic [1:0] sel, input int idx, input logic [AW-1:0] data,
                      input logic [1:0] want, input string req);
        logic [1:0]    code;
        logic [NE-1:0] chg;
        logic [3:0]    op;
        @(negedge clk);
        cur_req = req;
        wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = data;
        code = 2'd0;
        chg  = '0;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (sel == 0) begin
            if (idx >= NE) code = 3;
            else if (data[7:0] != m_cfg[idx]) begin
                op = {data[7], data[0], data[1], data[2]};
                if (entry_locked(idx)) code = 1;
                else if (m_ld && !m_bp && (op == 9 || op == 10 || op == 11 || op == 13)) code = 2;
                else m_cfg[idx] = data[7:0];
            end
        end else if (sel == 1) begin
            if (idx >= NE) code = 3;
            else if (data != m_addr[idx]) begin
                if (idx + 1 < NE && entry_locked(idx + 1) && m_cfg[idx+1][4:3] == 2'b01) code = 1;
                else if (entry_locked(idx)) code = 1;
                else begin
                    m_addr[idx] = data;
                    chg[idx] = 1'b1;
                    if (idx + 1 < NE && m_cfg[idx+1][4:3] == 2'b01) chg[idx+1] = 1'b1;
                end
            end
        end else if (sel == 2) begin
            bit any_l = 0;
            for (int i = 0; i < NE; i++) any_l |= m_cfg[i][7];
            m_ld = m_ld | data[0];
            m_wl = m_wl | data[1];
            if (data[2] && !m_bp && any_l) code = 1;
            else m_bp = data[2];
        end else begin
            code = 3;
        end
        exp_ack = 1'b1; exp_code = code; exp_chg = chg;
        check(ack_code == want, req, "intended code", AW'(ack_code), AW'(want));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        cur_req = "R11";
        repeat (3) @(negedge clk);
        check({ack_valid, rule_chg, sec_mml, sec_mmwp, sec_rlb} == '0, "R11", "reset outputs",
              AW'({ack_valid, rule_chg, sec_mml, sec_mmwp, sec_rlb}), '0);
        // R1 byte layout and readback.
        wr(0, 0, 32'hFFFF_FF1B, 0, "R1");
        wr(0, 0, 32'h0000_001B, 0, "R4");
        wr(1, 0, 32'h1000, 0, "R9");
        wr(1, 0, 32'h1000, 0, "R4");
        wr(0, 1, 32'h09, 0, "R1");
        wr(1, 0, 32'h2000, 0, "R9");
        // R2 lock on an entry.
        wr(0, 2, 32'h81, 0, "R2");
        wr(0, 2, 32'h83, 1, "R2");
        wr(1, 2, 32'h40, 1, "R2");
        wr(0, 2, 32'h81, 0, "R4");
        // R5 successor in top-of-range mode.
        wr(0, 5, 32'h89, 0, "R5");
        wr(1, 4, 32'h50, 1, "R5");
        wr(0, 7, 32'h99, 0, "R5");
        wr(1, 6, 32'h60, 0, "R5");
        wr(1, 7, 32'h70, 1, "R2");
        // R6 bypass request with locks present.
        wr(2, 0, 32'h4, 1, "R6");
        // R7 sticky bits.
        wr(2, 0, 32'h1, 0, "R7");
        wr(2, 0, 32'h2, 0, "R7");
        wr(2, 0, 32'h0, 0, "R7");
        // R3 forbidden encodings under lockdown.
        wr(0, 3, 32'h85, 2, "R3");
        wr(0, 3, 32'h84, 2, "R3");
        wr(0, 3, 32'h82, 2, "R3");
        wr(0, 3, 32'h86, 2, "R3");
        wr(0, 3, 32'h05, 0, "R3");
        wr(0, 3, 32'h87, 0, "R3");
        // R8 out of range and reserved select.
        wr(0, 9, 32'h1, 3, "R8");
        wr(1, 15, 32'h1, 3, "R8");
        wr(0, 8, 32'h3, 3, "R8");
        wr(3, 0, 32'h0, 3, "R8");
        // Bypass path from a clean state.
        do_reset();
        wr(2, 0, 32'h4, 0, "R6");
        wr(0, 0, 32'h80, 0, "R2");
        wr(0, 0, 32'h81, 0, "R2");
        wr(2, 0, 32'h5, 0, "R7");
        wr(0, 1, 32'h84, 0, "R3");
        wr(1, 0, 32'h700, 0, "R2");
        wr(2, 0, 32'h1, 0, "R6");
        wr(0, 0, 32'h83, 1, "R2");
        wr(2, 0, 32'h5, 1, "R6");
        cur_req = "R8";
        repeat (70) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule